// File: doc/BRIEF.md
# RTC Interrupt Flag and Rate Unit

This block produces the three interrupt conditions of a PC-style real-time clock: a programmable periodic event, an alarm event and an update-ended event. A free-running divider counts ticks of a 32.768 kHz reference, delivered as a one-cycle `ref_tick` enable in the system clock domain, and a 4-bit exponent code picks how often the periodic event fires. The alarm comparator and the timekeeping chain sit outside the block and supply one-cycle `alarm_hit` and `update_done` pulses.

Each event sets a raw flag whether or not its enable is set. A summary bit, which is also the `irq` output, is high while at least one raw flag has its enable set. The host reaches three registers through a simple select/read/write port. Reading the status register returns the flags and the summary and clears the flags. An event that lands in the same cycle as that read still leaves its flag set.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the rate register (select 0) reads 0x06, the control register (select 1) reads 0x00, the status register (select 2) reads 0x00 and `irq` is low.
- R2: With rate code n in 1..15, a periodic event fires once every 2^(n-1) reference ticks, which is 2^(16-n) Hz from a 32768 Hz reference. The reset code 6 therefore gives one event per 32 ticks.
- R3: With rate code 0, no periodic event fires, however many reference ticks arrive.
- R4: A periodic event sets the periodic flag (status bit 6). An `alarm_hit` pulse sets the alarm flag (bit 5), and an `update_done` pulse sets the update flag (bit 4). Each flag sets even when its enable is clear.
- R5: Status bit 7 and `irq` are both high exactly when some flag in status bits 6..4 is set and the control bit in the same position (6 periodic, 5 alarm, 4 update) is set.
- R6: A read of select 2 returns {summary, periodic, alarm, update, 4'b0000} in the same cycle. It clears all flags at the clock edge that ends the read, so `irq` is low from the next cycle unless a new event arrives.
- R7: If an event arrives in the same cycle as a status read, its flag is set after that edge.
- R8: The control register is 8 bits of read/write storage. Writes to select 2 or 3 change no register, and select 3 reads 0x00.
- R9: A write to select 0 stores the low 4 bits of the write data as the rate code. Bits 7..4 of the rate register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| alarm_hit | input | 1 | One-cycle alarm-match pulse |
| update_done | input | 1 | One-cycle update-ended pulse |
| reg_sel | input | 2 | Register select: 0 rate, 1 control, 2 status, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; on select 2 it clears the flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Interrupt output, same as status bit 7 |

## Verification
A write takes effect at the edge that ends its cycle. An event input or a reference tick sets its flag at the next edge, and `irq` follows in the same cycle as the flag. Read data is combinational, so it is sampled in the read cycle, and the clear is seen from the following cycle. The bench drives inputs at the falling edge and samples after it, and it measures periodic rates as the number of cycles between two consecutive `irq` rises, with a status read clearing the flag in between. A gap of four cycles between ticks keeps every period at least four cycles long for the fastest codes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_LSB  = 4;
  localparam int unsigned SUM_BIT   = 7;

  localparam logic [SEL_W-1:0] SEL_RATE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

  // flag vector order: index 0 update, 1 alarm, 2 periodic
  typedef enum int unsigned {
    FLG_UPD = 0,
    FLG_ALM = 1,
    FLG_PER = 2
  } flag_idx_e;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [RATE_W-1:0] rate_code,
  output logic              per_evt
);
  localparam int unsigned DIV_W = (1 << RATE_W) - 2;

  logic [DIV_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    cnt_d = cnt_q;
    if (ref_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // code n needs n-1 low counter bits all ones
  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i + 1 < int'(rate_code)) mask[i] = 1'b1;
    end
  end

  always_comb begin
    per_evt = ref_tick && (rate_code != '0) && ((cnt_q & mask) == mask);
  end

  // R2: fastest code fires on every reference tick
  assert_every_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && rate_code == RATE_W'(1)) |-> per_evt);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt,
  input  logic          clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic          summary
);
  logic [NF-1:0] flag_q, flag_d;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr)    flag_d[g] = 1'b0;
      if (evt[g]) flag_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end

    // R4 and R7: an event always leaves its flag set
    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flag_q[g]);

    // R6: a read with no event clears the flag
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[g]) |=> !flag_q[g]);
  end

  always_comb begin
    flags   = flag_q;
    summary = |(flag_q & en);
  end
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned RATE_W     = 4,
  parameter int unsigned RATE_RESET = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     reg_sel,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic                 summary,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [NUM_FLAGS-1:0] ctrl_en,
  output logic [RATE_W-1:0]    rate_q,
  output logic                 stat_rd
);
  logic [REG_W-1:0]  ctrl_q, ctrl_d;
  logic [RATE_W-1:0] rate_d;
  logic              ctrl_we, rate_we;

  always_comb begin
    ctrl_we = reg_wr && (reg_sel == SEL_CTRL);
    rate_we = reg_wr && (reg_sel == SEL_RATE);
    ctrl_d  = ctrl_we ? reg_wdata : ctrl_q;
    rate_d  = rate_we ? reg_wdata[RATE_W-1:0] : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= RATE_W'(RATE_RESET);
    end else begin
      ctrl_q <= ctrl_d;
      rate_q <= rate_d;
    end
  end

  always_comb begin
    stat_rd = reg_rd && (reg_sel == SEL_STAT);
    ctrl_en = ctrl_q[FLAG_LSB +: NUM_FLAGS];
    unique case (reg_sel)
      SEL_RATE: reg_rdata = REG_W'(rate_q);
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_STAT: begin
        reg_rdata = '0;
        reg_rdata[SUM_BIT] = summary;
        reg_rdata[FLAG_LSB +: NUM_FLAGS] = flags;
      end
      default:  reg_rdata = '0;
    endcase
  end

  // R8: a write elsewhere leaves control unchanged
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int unsigned RATE_W     = 4,
  parameter int unsigned RATE_RESET = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             alarm_hit,
  input  logic             update_done,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic                 rst_s1_q, rst_s2_q, rst_int_n;
  logic                 per_evt, stat_rd, summary;
  logic [RATE_W-1:0]    rate_q;
  logic [NUM_FLAGS-1:0] evt, flags, ctrl_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  rtc_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .ref_tick(ref_tick),
    .rate_code(rate_q), .per_evt(per_evt)
  );

  always_comb begin
    evt = '0;
    evt[FLG_PER] = per_evt;
    evt[FLG_ALM] = alarm_hit;
    evt[FLG_UPD] = update_done;
  end

  rtc_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .evt(evt), .clr(stat_rd),
    .en(ctrl_en), .flags(flags), .summary(summary)
  );

  rtc_host_regs #(.RATE_W(RATE_W), .RATE_RESET(RATE_RESET)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .flags(flags),
    .summary(summary), .reg_rdata(reg_rdata), .ctrl_en(ctrl_en),
    .rate_q(rate_q), .stat_rd(stat_rd)
  );

  assign irq = summary;

  // R3: code zero silences the divider
  assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rate_q == '0) |-> !per_evt);

  // R5: no interrupt without an enable
  assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (ctrl_en != '0));

  // R6: a quiet status read drops the interrupt
  assert_read_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_rd && evt == '0) |=> !irq);
endmodule

// File: tb/test_rtc_irq_unit.sv
module test_rtc_irq_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ref_tick = 1'b0, alarm_hit = 1'b0, update_done = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rtc_irq_unit i_rtc_irq_unit (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alarm_hit(alarm_hit),
    .update_done(update_done), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #2 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    #2;
  endtask

  task automatic pulse(input logic p, input logic a, input logic u);
    @(negedge clk);
    ref_tick = p; alarm_hit = a; update_done = u;
    @(negedge clk);
    ref_tick = 1'b0; alarm_hit = 1'b0; update_done = 1'b0;
    #2;
  endtask

  // set flags {periodic, alarm, update} through the inputs
  task automatic setf(input logic [2:0] f);
    wr(2'd0, 8'd1);
    pulse(f[2], f[1], f[0]);
    wr(2'd0, 8'd0);
    #2;
  endtask

  // cycles between two consecutive irq rises, flag cleared in between
  task automatic measure(input int code, input int gap, input bit do_wr, input string tag);
    logic [7:0] v;
    int first, found, lim, expct;
    wr(2'd1, 8'h40);
    if (do_wr) wr(2'd0, 8'(code));
    rd(2'd2, v);
    expct = (1 << (code - 1)) * gap;
    lim = 3 * expct + 20;
    first = 0; found = 0;
    for (int c = 0; c < lim && found < 2; c++) begin
      @(negedge clk);
      ref_tick = ((c % gap) == 0);
      reg_sel = 2'd2;
      reg_rd = 1'b0;
      if (irq) begin
        if (found == 0) first = c;
        else chk($sformatf("%s code %0d period", tag, code), c - first, expct);
        found++;
        reg_rd = 1'b1;
      end
    end
    @(negedge clk);
    ref_tick = 1'b0; reg_rd = 1'b0;
    if (found < 2) chk($sformatf("%s code %0d events seen", tag, code), found, 2);
  endtask

  initial begin : main
    logic [7:0] v;
    logic [7:0] ctl;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #2 chk("R1 irq", int'(irq), 0);
    rd(2'd0, v); chk("R1 rate", v, 8'h06);
    rd(2'd1, v); chk("R1 control", v, 8'h00);
    rd(2'd2, v); chk("R1 status", v, 8'h00);

    // R2 reset code 6 gives 32 ticks per event
    measure(6, 1, 1'b0, "R2 reset-code");

    // R2 sweep of all nonzero codes
    for (int n = 1; n <= 15; n++) measure(n, (n <= 3) ? 4 : 1, 1'b1, "R2");

    // R3 code 0 silent
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h00);
    rd(2'd2, v);
    seen = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      ref_tick = 1'b1;
      if (irq) seen++;
    end
    @(negedge clk); ref_tick = 1'b0;
    chk("R3 irq count with code 0", seen, 0);
    rd(2'd2, v); chk("R3 status with code 0", v, 8'h00);

    // R4 flags set with enables clear
    wr(2'd1, 8'h00);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R4 irq stays low", int'(irq), 0);
    rd(2'd2, v); chk("R4 alarm flag", v, 8'h20);
    pulse(1'b0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R4 update flag", v, 8'h10);
    setf(3'b100);
    rd(2'd2, v); chk("R4 periodic flag", v, 8'h40);
    rd(2'd2, v); chk("R6 cleared after read", v, 8'h00);

    // R5 and R6 exhaustive enables x flags
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        ctl = {1'b1, 3'(e), 4'hA};
        wr(2'd1, ctl);
        rd(2'd2, v);
        setf(3'(f));
        chk($sformatf("R5 irq e=%0d f=%0d", e, f), int'(irq), int'((e & f) != 0));
        rd(2'd2, v);
        chk($sformatf("R5 R6 status e=%0d f=%0d", e, f), v,
            {((e & f) != 0) ? 1'b1 : 1'b0, 3'(f), 4'h0});
        chk($sformatf("R6 irq after read e=%0d f=%0d", e, f), int'(irq), 0);
      end
    end

    // R7 event in the read cycle survives
    wr(2'd1, 8'h20);
    rd(2'd2, v);
    @(negedge clk);
    reg_sel = 2'd2; reg_rd = 1'b1; alarm_hit = 1'b1;
    #2 v = reg_rdata;
    chk("R7 status during read", v, 8'h00);
    @(negedge clk);
    reg_rd = 1'b0; alarm_hit = 1'b0;
    #2 chk("R7 irq after collision", int'(irq), 1);
    rd(2'd2, v); chk("R7 status after collision", v, 8'hA0);

    // R8 control storage and ignored writes
    wr(2'd1, 8'hA5);
    rd(2'd1, v); chk("R8 control readback", v, 8'hA5);
    wr(2'd0, 8'h09);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R8 status write ignored", v, 8'h00);
    wr(2'd3, 8'h3C);
    rd(2'd3, v); chk("R8 select 3 reads zero", v, 8'h00);
    rd(2'd1, v); chk("R8 control unchanged", v, 8'hA5);
    rd(2'd0, v); chk("R8 rate unchanged", v, 8'h09);

    // R9 rate keeps low nibble
    wr(2'd0, 8'hF3);
    rd(2'd0, v); chk("R9 rate low nibble", v, 8'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule